// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when an 8-bit timer advances. A 10-bit prescaler runs continuously on the system clock. A 3-bit select field chooses what drives the timer. It can choose nothing, the raw system clock, one of four divided rates, or a chosen edge on an external event input. The output is a count-enable strobe that lasts one system cycle. It is not a derived clock, so the timer, its compare logic and this block all run on the same clock edge.

The external input is first retimed by a two-stage synchronizer and then passed to an edge detector. Each detected edge of the chosen polarity produces exactly one strobe, so external events must change no faster than half the system clock rate. A synchronous clear input restarts the prescaler from zero. Software can use it to align the first divided strobe to a known moment.

Top module: `timer_tick_select`

## Requirements
- R1: With select code 0, `cnt_en` stays low every cycle, so the timer is frozen.
- R2: With select code 1, `cnt_en` is high in every cycle.
- R3: With select codes 2, 3, 4 and 5, `cnt_en` is a one-cycle pulse that repeats every 8, 64, 256 and 1024 cycles respectively.
- R4: If `presc_clr` is high in cycle c, then with a divided code of ratio N the next pulses fall in cycles c+N, c+2N, and so on. A pulse in cycle c itself comes from the previous phase.
- R5: The prescaler counts whatever the select code is. Switching between divided codes without a clear keeps the phase, so every pulse lands a whole number of new ratios after the last clear.
- R6: With select code 6, a high-to-low change of `ext_evt` driven in cycle c gives exactly one pulse, in cycle c+2. Low-to-high changes give none.
- R7: With select code 7, a low-to-high change of `ext_evt` driven in cycle c gives exactly one pulse, in cycle c+2. High-to-low changes give none.
- R8: An external level held for any number of cycles after its edge gives a single pulse, never a train.
- R9: While `rst_n` is low, `cnt_en` is low whatever the select code. In the first cycle r with `rst_n` high, the prescaler is zero, so with ratio N the first pulse falls in cycle r+N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop samples on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_clr | input | 1 | Synchronous clear of the prescaler counter |
| src_sel | input | 3 | Source code: 0 off, 1 every cycle, 2 /8, 3 /64, 4 /256, 5 /1024, 6 falling external edge, 7 rising external edge |
| ext_evt | input | 1 | Asynchronous external event input |
| cnt_en | output | 1 | One-cycle count-enable strobe for the timer |

## Verification
A prescaler that has lost its phase shows up as divided strobes at the wrong distance from the last clear or from the previous strobe. The first wrong strobe appears within one ratio period, which is at most 1024 cycles. A broken synchronizer or edge detector shows up as a strobe one cycle early or late, as a strobe on the wrong polarity, or as a train of strobes while the pin is held. Each of these is visible two cycles after the pin moves. A bad select decode shows up as a strobe under code 0 or as a gap under code 1, and both appear in the very next cycle.

// File: rtl/timer_tick_pkg.sv
// Package: shared constants, source-select codes and tap geometry for the
// timer tick selector. Assumes tap widths never exceed PRESC_W.
package timer_tick_pkg;

    localparam int PRESC_W   = 10;   // prescaler counter width
    localparam int NUM_TAPS  = 4;    // number of divided rates
    localparam int SEL_W     = 3;    // width of the source select field
    localparam int SYNC_LEN  = 2;    // synchronizer depth for the event pin

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'd0,
        SRC_DIV1     = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_EXT_FALL = 3'd6,
        SRC_EXT_RISE = 3'd7
    } src_sel_e;

    // log2 of the division ratio for tap index idx (0 -> /8 ... 3 -> /1024)
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
// Free-running prescaler. A CNT_W-bit counter advances every system cycle.
// Each tap flags the cycle in which its low bits are all ones, i.e. the
// cycle just before they wrap to zero, so a tap of width L is high once
// every 2**L cycles. Reset and clr both force the counter to zero.
// Assumes every tap width is between 1 and CNT_W.
module tick_prescaler #(
    parameter int CNT_W = timer_tick_pkg::PRESC_W,
    parameter int TAPS  = timer_tick_pkg::NUM_TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [TAPS-1:0] tap_hit
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the prescaler, or restart it from zero on reset/clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One wrap detector per division tap.
    for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
        localparam int LW = timer_tick_pkg::tap_log2(gi);
        // Purpose: flag the last cycle before this tap's low bits wrap.
        assign tap_hit[gi] = &cnt_q[LW-1:0];
    end

endmodule

// File: rtl/ext_edge_detect.sv
// Retimes an asynchronous event pin through SYNC_STAGES flops and then
// compares the settled level with its value one cycle earlier. Each edge
// yields a rise or fall flag for exactly one cycle. Assumes the pin stays
// at a level for at least two system cycles and SYNC_STAGES >= 2.
module ext_edge_detect #(
    parameter int SYNC_STAGES = timer_tick_pkg::SYNC_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   settled;

    assign settled = sync_q[SYNC_STAGES-1];

    // Purpose: shift the pin through the synchronizer and keep the prior level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            last_q <= settled;
        end
    end

    // Purpose: turn a level change of the settled pin into a one-cycle flag.
    assign rise = settled & ~last_q;
    assign fall = ~settled & last_q;

endmodule

// File: rtl/tick_source_mux.sv
// Chooses the count-enable source from the select code: nothing, every
// cycle, one of the prescaler taps, or an external edge flag. The output
// is forced low while run is low. Purely combinational.
module tick_source_mux #(
    parameter int TAPS = timer_tick_pkg::NUM_TAPS,
    parameter int SW   = timer_tick_pkg::SEL_W
) (
    input  logic            run,
    input  logic [SW-1:0]   sel,
    input  logic [TAPS-1:0] tap_hit,
    input  logic            ext_rise,
    input  logic            ext_fall,
    output logic            en
);
    import timer_tick_pkg::*;

    // Purpose: decode the select code into a single enable strobe.
    always_comb begin
        case (sel)
            SRC_OFF:      en = 1'b0;
            SRC_DIV1:     en = 1'b1;
            SRC_DIV8:     en = tap_hit[0];
            SRC_DIV64:    en = tap_hit[1];
            SRC_DIV256:   en = tap_hit[2];
            SRC_DIV1024:  en = tap_hit[TAPS-1];
            SRC_EXT_FALL: en = ext_fall;
            SRC_EXT_RISE: en = ext_rise;
            default:      en = 1'b0;
        endcase
        if (!run) begin
            en = 1'b0;
        end
    end

endmodule

// File: rtl/timer_tick_select.sv
// Top of the timer tick selector. It joins the free-running prescaler, the
// event-pin synchronizer with its edge detector, and the source mux. All
// logic runs on clk. The strobe on cnt_en is meant for a counter in the
// same clock domain. The prescaler keeps running whatever the select code.
module timer_tick_select
    import timer_tick_pkg::*;
#(
    parameter int CNT_W = PRESC_W,
    parameter int TAPS  = NUM_TAPS,
    parameter int SYNC  = SYNC_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_clr,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             ext_evt,
    output logic             cnt_en
);

    logic [TAPS-1:0] tap_hit;
    logic            ext_rise;
    logic            ext_fall;

    // Prescaler with its division taps.
    tick_prescaler #(
        .CNT_W (CNT_W),
        .TAPS  (TAPS)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (presc_clr),
        .tap_hit (tap_hit)
    );

    // Synchronizer and edge detector for the event pin.
    ext_edge_detect #(
        .SYNC_STAGES (SYNC)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_evt),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Source selection.
    tick_source_mux #(
        .TAPS (TAPS),
        .SW   (SEL_W)
    ) u_mux (
        .run      (rst_n),
        .sel      (src_sel),
        .tap_hit  (tap_hit),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .en       (cnt_en)
    );

endmodule

// File: rtl/timer_tick_select_chk.sv
// Checker for timer_tick_select. It sees only the top-level ports. It keeps
// its own gap counter to check the spacing of divided strobes, and a short
// counter of cycles since reset to guard its look-back on the event pin.
module timer_tick_select_chk
    import timer_tick_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             presc_clr,
    input logic [SEL_W-1:0] src_sel,
    input logic             ext_evt,
    input logic             cnt_en
);

    function automatic int unsigned div_ratio(input logic [SEL_W-1:0] s);
        return int'(unsigned'(1) << tap_log2(int'(s) - 2));
    endfunction

    logic             is_div;
    logic             armed_q;
    logic [SEL_W-1:0] armed_sel_q;
    int unsigned      gap_q;
    logic [2:0]       since_q;

    assign is_div = (src_sel >= SRC_DIV8) && (src_sel <= SRC_DIV1024);

    // Purpose: measure cycles since the last strobe or clear under a steady divided code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            armed_sel_q <= '0;
            gap_q       <= 0;
        end else begin
            if (presc_clr || cnt_en) begin
                gap_q <= 1;
            end else if (gap_q < 4095) begin
                gap_q <= gap_q + 1;
            end
            if (!is_div) begin
                armed_q <= 1'b0;
            end else if (presc_clr || cnt_en) begin
                armed_q     <= 1'b1;
                armed_sel_q <= src_sel;
            end else if (src_sel != armed_sel_q) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Purpose: count cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != 3'd7) begin
            since_q <= since_q + 3'd1;
        end
    end

    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_OFF) |-> !cnt_en);

    a_r2_div1_every: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_DIV1) |-> cnt_en);

    // R3 and R4: a strobe never comes early relative to the last strobe or clear.
    a_r3_ratio_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && armed_q && is_div && src_sel == armed_sel_q)
        |-> (gap_q == div_ratio(src_sel)));

    // R3 and R4: a strobe is never missing once a full ratio has elapsed.
    a_r4_no_missing: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && is_div && src_sel == armed_sel_q && gap_q == div_ratio(src_sel))
        |-> cnt_en);

    a_r6_fall_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_EXT_FALL && since_q >= 3'd4 &&
         !$past(ext_evt, 2) && $past(ext_evt, 3)) |-> cnt_en);

    a_r7_rise_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_EXT_RISE && since_q >= 3'd4 &&
         $past(ext_evt, 2) && !$past(ext_evt, 3)) |-> cnt_en);

    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_EXT_RISE && cnt_en) |=> !(cnt_en && src_sel == SRC_EXT_RISE));

    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_EXT_FALL && cnt_en) |=> !(cnt_en && src_sel == SRC_EXT_FALL));

    // Purpose: R9, no strobe while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r9_reset_quiet: assert (!cnt_en)
                else $error("cnt_en high during reset");
        end
    end

endmodule

bind timer_tick_select timer_tick_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_clr (presc_clr),
    .src_sel   (src_sel),
    .ext_evt   (ext_evt),
    .cnt_en    (cnt_en)
);

// File: tb/sim_timer_tick_select.sv
// Scoreboard bench: driver tasks push the expected strobe cycles into a
// queue, and a monitor at each falling clock edge pops and compares them.
module sim_timer_tick_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_clr = 1'b0;
    logic [2:0] src_sel = 3'd1;
    logic       ext_evt = 1'b0;
    logic       cnt_en;

    always #10 clk = ~clk;   // 50 MHz

    timer_tick_select u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_clr (presc_clr),
        .src_sel   (src_sel),
        .ext_evt   (ext_evt),
        .cnt_en    (cnt_en)
    );

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    exp_q[$];
    bit    mon_on = 1'b0;
    string mon_tag = "";
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: match each strobe, and each expected strobe, against the queue.
    always @(negedge clk) begin
        if (mon_on) begin
            if (cnt_en) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s: strobe at cycle %0d, expected none", mon_tag, cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        fails++;
                        $display("FAIL %s: strobe at cycle %0d, expected cycle %0d", mon_tag, cyc, e);
                    end
                end
            end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                checks++;
                fails++;
                $display("FAIL %s: no strobe at cycle %0d (actual 0, expected 1)", mon_tag, cyc);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic open_win(input string tag);
        mon_tag = tag;
        mon_on  = 1'b1;
    endtask

    task automatic close_win();
        mon_on = 1'b0;
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected strobes left (actual %0d, expected 0)",
                     mon_tag, exp_q.size(), exp_q.size());
            exp_q.delete();
        end
    endtask

    // Push strobes of ratio n phased from clear cycle c0 that fall in [lo, hi].
    task automatic push_div(input int c0, input int n, input int lo, input int hi);
        for (int k = 1; c0 + k * n <= hi; k++) begin
            if (c0 + k * n >= lo) exp_q.push_back(c0 + k * n);
        end
    endtask

    // R3 and R4: clear the prescaler together with a code change and watch three periods.
    task automatic run_div(input logic [2:0] code, input int n, input string tag);
        int c;
        src_sel   = code;
        presc_clr = 1'b1;
        c = cyc;
        step();
        presc_clr = 1'b0;
        push_div(c, n, c + 1, c + 3 * n + 2);
        open_win(tag);
        step(3 * n + 2);
        close_win();
    endtask

    initial begin
        int r;
        int c;
        // R9: reset holds the strobe low even with the every-cycle code.
        step(3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (cnt_en !== 1'b0) begin
                fails++;
                $display("FAIL R9: cnt_en during reset actual %b expected 0", cnt_en);
            end
        end
        step();
        src_sel = 3'd2;
        rst_n   = 1'b1;
        r = cyc;
        exp_q.push_back(r + 7);
        exp_q.push_back(r + 15);
        exp_q.push_back(r + 23);
        open_win("R9 first /8 after reset");
        step(30);
        close_win();

        // R1: code 0 produces nothing for more than the longest period.
        src_sel = 3'd0;
        step();
        open_win("R1 off");
        step(2100);
        close_win();

        // R2: code 1 produces a strobe in every cycle.
        src_sel = 3'd1;
        step();
        for (int i = 0; i < 20; i++) exp_q.push_back(cyc + i);
        open_win("R2 every cycle");
        step(20);
        close_win();

        run_div(3'd2, 8,    "R3/R4 div8");
        run_div(3'd3, 64,   "R3/R4 div64");
        run_div(3'd4, 256,  "R3/R4 div256");
        run_div(3'd5, 1024, "R3/R4 div1024");

        // R5: switching from /64 to /8 without a clear keeps the phase.
        src_sel   = 3'd3;
        presc_clr = 1'b1;
        c = cyc;
        step();
        presc_clr = 1'b0;
        push_div(c, 64, c + 1, c + 99);
        push_div(c, 8, c + 100, c + 199);
        open_win("R5 phase kept");
        step(99);
        src_sel = 3'd2;
        step(100);
        close_win();

        // R6: falling edges only, each two cycles after the pin change.
        src_sel = 3'd6;
        ext_evt = 1'b0;
        step(4);
        open_win("R6 falling edge");
        ext_evt = 1'b1;
        step(5);
        ext_evt = 1'b0;
        exp_q.push_back(cyc + 2);
        step(3);
        ext_evt = 1'b1;
        step(2);
        ext_evt = 1'b0;
        exp_q.push_back(cyc + 2);
        step(6);
        close_win();

        // R7 and R8: rising edges only, one strobe while the level is held.
        src_sel = 3'd7;
        step(4);
        open_win("R7/R8 rising edge held");
        ext_evt = 1'b1;
        exp_q.push_back(cyc + 2);
        step(12);
        ext_evt = 1'b0;
        step(4);
        ext_evt = 1'b1;
        exp_q.push_back(cyc + 2);
        step(3);
        ext_evt = 1'b0;
        step(4);
        close_win();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule